// File: doc/BRIEF.md
# Self-Clearing Reset Command Register

This block is a 32-bit control register that a host writes to issue reset commands to the subsystems of a data-acquisition device: the board as a whole, the analog input converter, the analog outputs, the digital I/O groups and the converter's sample FIFO. Each command bit is self-clearing. Writing 1 produces a reset pulse one clock cycle wide on that subsystem's output, and the bit never holds a 1 afterwards.

The same word also holds one level bit that powers the analog input converter down. This bit keeps the last value written to it until it is overwritten or until a board reset clears it.

A board-reset command reaches every subsystem. It pulses all the other reset outputs in the same cycle and releases the converter from power-down. The register accepts only full 32-bit writes. A write with any byte lane disabled is discarded as a whole.

Top module: `rstCmdReg`

## Requirements
- R1: After reset, every pulse output, `adcPowerDown` and `rdData` are 0.
- R2: A full-width write with bit 6 set drives `fifoRst` high for exactly one cycle. The pulse appears in the cycle after the write is sampled.
- R3: A full-width write sets bit 1, bit 3 or bit 5 to pulse `adcRst`, `dacRst` or `dioRst` for one cycle with the same timing as R2. Several bits in one word pulse their outputs together.
- R4: A full-width write with bit 0 set pulses `boardRst` and also pulses `adcRst`, `dacRst`, `dioRst` and `fifoRst` in the same cycle.
- R5: A board-reset write forces `adcPowerDown` to 0 in the pulse cycle, even if the same word has bit 2 set.
- R6: When bit 0 is clear, a full-width write loads bit 2 into `adcPowerDown`, where 1 means powered down. The value holds until the next such write.
- R7: `rdData` returns the power-down level at bit 2. Every other bit reads 0, including the command bits, bit 4 and bits 31..7. Writing 1 to bit 4 or to bits 31..7 changes no output.
- R8: Writing 0 to a command bit produces no pulse on its output.
- R9: A write with `wrStrb` other than 4'b1111 changes no output and produces no pulse.
- R10: Full-width writes on consecutive cycles each produce their own pulse, one cycle after each write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write request |
| wrStrb | input | 4 | Byte-lane enables; only 4'b1111 is accepted |
| wrData | input | 32 | Write data word |
| rdData | output | 32 | Read data word |
| boardRst | output | 1 | One-cycle board reset pulse |
| adcRst | output | 1 | One-cycle analog input reset pulse |
| dacRst | output | 1 | One-cycle analog output reset pulse |
| dioRst | output | 1 | One-cycle digital I/O reset pulse |
| fifoRst | output | 1 | One-cycle sample FIFO reset pulse |
| adcPowerDown | output | 1 | Converter power-down level |

## Verification
A board-reset command and a power-down write can land in the same word, and a board reset also coincides with every explicit subsystem command. The bench provokes both by sweeping all 128 values of bits 6..0, with the prior power-down level at both 0 and 1, and with junk in the reserved bits. It predicts each output arithmetically: each pulse is its own bit OR bit 0, and the power-down level is 0 when bit 0 is set and bit 2 otherwise. A second overlap comes from back-to-back writes, where a new command is sampled while the previous pulse is still high. The bench checks that each pulse follows its own write.

// File: rtl/rstCmdPkg.sv
package rstCmdPkg;
  localparam int DATA_W  = 32;
  localparam int STRB_W  = DATA_W / 8;
  localparam int NUM_SUB = 5;
  // subsystem index order: board first, it cascades into the rest
  localparam int SUB_BOARD = 0;
  localparam int SUB_ADC   = 1;
  localparam int SUB_DAC   = 2;
  localparam int SUB_DIO   = 3;
  localparam int SUB_FIFO  = 4;
  localparam int BIT_PDN   = 2;

  function automatic int subBitPos(input int idx);
    case (idx)
      SUB_BOARD: return 0;
      SUB_ADC:   return 1;
      SUB_DAC:   return 3;
      SUB_DIO:   return 5;
      default:   return 6;
    endcase
  endfunction

  typedef struct packed {
    logic [NUM_SUB-1:0] cmd;
    logic               pdnLoad;
    logic               pdnValue;
  } cmdStrobes_t;
endpackage

// File: rtl/rstCmdCtrl.sv
module rstCmdCtrl
  import rstCmdPkg::*;
(
  input  logic              wrEn,
  input  logic [STRB_W-1:0] wrStrb,
  input  logic [DATA_W-1:0] wrData,
  output cmdStrobes_t       strobes
);
  logic fullWr;
  assign fullWr = wrEn && (wrStrb == {STRB_W{1'b1}});

  for (genvar i = 0; i < NUM_SUB; i++) begin : g_dec
    localparam logic [DATA_W-1:0] SEL = DATA_W'(1) << subBitPos(i);
    assign strobes.cmd[i] = fullWr && |(wrData & SEL);
  end

  localparam logic [DATA_W-1:0] PDN_SEL = DATA_W'(1) << BIT_PDN;
  assign strobes.pdnLoad  = fullWr;
  assign strobes.pdnValue = |(wrData & PDN_SEL);
endmodule

// File: rtl/rstCmdDatapath.sv
module rstCmdDatapath
  import rstCmdPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  cmdStrobes_t        strobes,
  output logic [NUM_SUB-1:0] pulseQ,
  output logic               pdnQ,
  output logic [DATA_W-1:0]  rdWord
);
  logic boardCmd;
  assign boardCmd = strobes.cmd[SUB_BOARD];

  for (genvar i = 0; i < NUM_SUB; i++) begin : g_pulse
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pulseQ[i] <= 1'b0;
      else       pulseQ[i] <= strobes.cmd[i] | boardCmd;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                pdnQ <= 1'b0;
    else if (boardCmd)        pdnQ <= 1'b0;
    else if (strobes.pdnLoad) pdnQ <= strobes.pdnValue;
  end

  always_comb begin
    rdWord = '0;
    rdWord[BIT_PDN] = pdnQ;
  end
endmodule

// File: rtl/rstCmdReg.sv
module rstCmdReg
  import rstCmdPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [STRB_W-1:0] wrStrb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              boardRst,
  output logic              adcRst,
  output logic              dacRst,
  output logic              dioRst,
  output logic              fifoRst,
  output logic              adcPowerDown
);
  cmdStrobes_t        strobes;
  logic [NUM_SUB-1:0] pulseQ;

  rstCmdCtrl u_ctrl (
    .wrEn(wrEn), .wrStrb(wrStrb), .wrData(wrData), .strobes(strobes)
  );

  rstCmdDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .pulseQ(pulseQ), .pdnQ(adcPowerDown), .rdWord(rdData)
  );

  assign boardRst = pulseQ[SUB_BOARD];
  assign adcRst   = pulseQ[SUB_ADC];
  assign dacRst   = pulseQ[SUB_DAC];
  assign dioRst   = pulseQ[SUB_DIO];
  assign fifoRst  = pulseQ[SUB_FIFO];
endmodule

// File: rtl/rstCmdChecker.sv
module rstCmdChecker (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [3:0]  wrStrb,
  input logic [31:0] wrData,
  input logic [31:0] rdData,
  input logic        boardRst,
  input logic        adcRst,
  input logic        dacRst,
  input logic        dioRst,
  input logic        fifoRst,
  input logic        adcPowerDown
);
  logic fullWr;
  assign fullWr = wrEn && (wrStrb == 4'hF);

  p_fifo_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    fullWr && wrData[6] |=> fifoRst);

  p_board_cascade_r4: assert property (@(posedge clk) disable iff (!rstN)
    boardRst |-> (adcRst && dacRst && dioRst && fifoRst));

  p_board_pdn_r5: assert property (@(posedge clk) disable iff (!rstN)
    boardRst |-> !adcPowerDown);

  p_read_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~32'h4) == 32'h0);

  p_no_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    !fullWr |=> ($stable(adcPowerDown) && !boardRst && !adcRst && !dacRst
                 && !dioRst && !fifoRst));

  p_zero_cmd_r8: assert property (@(posedge clk) disable iff (!rstN)
    fullWr && !wrData[0] && !wrData[3] |=> !dacRst);
endmodule

bind rstCmdReg rstCmdChecker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrStrb(wrStrb), .wrData(wrData),
  .rdData(rdData), .boardRst(boardRst), .adcRst(adcRst), .dacRst(dacRst),
  .dioRst(dioRst), .fifoRst(fifoRst), .adcPowerDown(adcPowerDown)
);

// File: tb/tb_rstCmdReg.sv
`timescale 1ns/1ps
module tb_rstCmdReg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrStrb = 4'h0;
  logic [31:0] wrData = 32'h0;
  logic [31:0] rdData;
  logic boardRst, adcRst, dacRst, dioRst, fifoRst, adcPowerDown;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #4 clk = ~clk;

  rstCmdReg dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrStrb(wrStrb), .wrData(wrData),
    .rdData(rdData), .boardRst(boardRst), .adcRst(adcRst), .dacRst(dacRst),
    .dioRst(dioRst), .fifoRst(fifoRst), .adcPowerDown(adcPowerDown)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {adcPowerDown, fifoRst, dioRst, dacRst, adcRst, boardRst};
  endfunction

  // drive at a falling edge, release at the next; outputs then show the result
  task automatic doWrite(input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    wrEn = 1'b1; wrData = d; wrStrb = s;
    @(negedge clk);
    wrEn = 1'b0; wrData = 32'h0; wrStrb = 4'h0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        nChecks++; nFails++;
        $display("FAIL watchdog expired");
        finishRun();
      end
    end
  end

  initial begin
    logic [5:0] expOuts;
    logic       pdnPrev;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {58'h0, outs()}, 64'h0);
    check("R1 reset rdData", {32'h0, rdData}, 64'h0);
    rstN = 1'b1;

    // sweep bits 6..0 with both prior power-down levels, junk in reserved bits
    for (int prior = 0; prior < 2; prior++) begin
      for (int v = 0; v < 128; v++) begin
        logic [31:0] word;
        logic b0;
        doWrite(prior ? 32'h4 : 32'h0, 4'hF);
        pdnPrev = prior[0];
        check("R6 power-down preset", {63'h0, adcPowerDown}, {63'h0, pdnPrev});
        word = {v[24:0], v[6:0]} | ((v % 3 == 0) ? 32'h0000_0010 : 32'h0);
        b0 = word[0];
        doWrite(word, 4'hF);
        expOuts[0] = b0;
        expOuts[1] = b0 | word[1];
        expOuts[2] = b0 | word[3];
        expOuts[3] = b0 | word[5];
        expOuts[4] = b0 | word[6];
        expOuts[5] = b0 ? 1'b0 : word[2];
        check("R2 R3 R4 R5 R6 R8 pulse cycle", {58'h0, outs()}, {58'h0, expOuts});
        check("R7 readback", {32'h0, rdData}, {61'h0, expOuts[5], 2'b00});
        @(negedge clk);
        check("R2 R3 one-cycle pulse", {59'h0, outs()[4:0]}, 64'h0);
        check("R6 level holds", {63'h0, adcPowerDown}, {63'h0, expOuts[5]});
      end
    end

    // partial-width writes are discarded
    doWrite(32'h4, 4'hF);
    for (int s = 0; s < 15; s++) begin
      doWrite(32'hFFFF_FF7B, s[3:0]);
      check("R9 partial write ignored", {58'h0, outs()}, {58'h0, 6'b100000});
    end
    // reserved and bit 4 only: no pulse, power-down follows bit 2 = 0
    doWrite(32'hFFFF_FF90, 4'hF);
    check("R7 reserved bits no effect", {58'h0, outs()}, 64'h0);
    check("R7 reserved readback", {32'h0, rdData}, 64'h0);

    // back-to-back writes
    @(negedge clk);
    wrEn = 1'b1; wrStrb = 4'hF; wrData = 32'h40;
    @(negedge clk);
    check("R10 first pulse", {59'h0, outs()[4:0]}, {59'h0, 5'b10000});
    wrData = 32'h20;
    @(negedge clk);
    check("R10 second pulse", {59'h0, outs()[4:0]}, {59'h0, 5'b01000});
    wrData = 32'h40;
    @(negedge clk);
    wrEn = 1'b0; wrData = 32'h0; wrStrb = 4'h0;
    check("R10 third pulse", {59'h0, outs()[4:0]}, {59'h0, 5'b10000});
    @(negedge clk);
    check("R10 quiet after", {59'h0, outs()[4:0]}, 64'h0);

    finishRun();
  end
endmodule